// File: doc/BRIEF.md
# L2 Bank Coherence Request Dispatcher

This block is the request controller for one bank of a shared on-chip L2 cache that is split into interleaved banks and serves eight private L1 caches. Each L1 request names a requesting CPU, a line address and whether it wants a read (shared) copy or an exclusive copy. In the cycle a request is offered, the dispatcher looks the line up in three register-based stores. The first is the bank's own L2 tags. The second is a duplicate of every L1's tags and coherence states for lines of this bank. The third is a per-line record of whether another node caches the line, shared or exclusive. From these lookups it chooses exactly one service path: reply from the L2, forward to the L1 that owns the line, hand the request to the inter-node protocol engine, or fetch from memory.

The L2 works as a victim store. A line enters it only when an L1 evicts that line, and a memory fetch does not install it. Forwards to an owning L1 are tracked in a small table until a completion pulse returns the line address. Until then, every later request to that line is held at the request port. Each of the four action outputs is a valid/ready channel that shares one payload. Only one action is outstanding at a time: while the current action is not taken, `req_ready` stays low and no new in-bank request enters. The request port follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` may depend on the offered request. Eviction, remote-record and completion inputs are plain one-cycle strobes.

Top module: `l2_bank_dispatch`

## Requirements
- R1: For an in-bank request, the action is chosen by priority. A remote conflict (R2) selects the protocol engine. Otherwise, another CPU holding the line exclusive selects a forward. Otherwise, an L2 tag hit selects an L2 reply. Otherwise, the request goes to memory.
- R2: The remote state code is 2'b00 none, 2'b01 shared, 2'b10 exclusive, and 2'b11 counts as exclusive. A remote exclusive copy conflicts with every request. A remote shared copy conflicts only with an exclusive request. A protocol-engine hand-off leaves the duplicate L1 state unchanged.
- R3: A forward drives `fwd_target` with the ID of the exclusive owner. On a read forward the owner drops to shared, so a later read by a third CPU is not forwarded. On an exclusive forward the owner is invalidated, and the requester becomes the new owner.
- R4: A line is installed in the L2 tags only on an L1 eviction strobe, which also removes the evicting CPU's duplicate copy. A memory fetch does not install the line.
- R5: Every dispatched request that is not handed to the protocol engine records the requester's duplicate entry as exclusive or shared, matching the request type. An exclusive request invalidates every other CPU's duplicate copy of the line.
- R6: While a forward to a line is outstanding, `req_ready` is low for any request to that line. A `fwd_done` strobe with that address releases the line, and the request is accepted from the next cycle on.
- R7: At most FWD_SLOTS forwards (default 4) are outstanding. A request that needs a forward while the table is full is stalled.
- R8: The bank index is `req_addr[BANK_BITS-1:0]`. A request whose index differs from BANK_ID is accepted with `req_ready` high, raises `bank_err` for exactly the one cycle after acceptance, drives no action and changes no state.
- R9: After an in-bank request is accepted, exactly one action valid is high in the next cycle. That cycle also carries `act_cpu`, `act_addr` and `act_excl` from the request.
- R10: While the raised action valid has its ready low, the valid and the payload hold steady and no in-bank request is accepted. When that ready rises, a waiting request may be accepted on the same edge that the old action is taken.
- R11: After reset, all action valids and `bank_err` are low and all stores are empty. An in-bank request then has `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_cpu | input | CPU_W | Requesting CPU ID |
| req_addr | input | ADDR_W | Line address; low BANK_BITS select the bank |
| req_excl | input | 1 | 1 = exclusive request, 0 = read |
| l2_valid | output | 1 | Reply-from-L2 action valid |
| l2_ready | input | 1 | Reply-from-L2 action taken |
| fwd_valid | output | 1 | Forward-to-owner action valid |
| fwd_ready | input | 1 | Forward action taken |
| pe_valid | output | 1 | Protocol-engine hand-off valid |
| pe_ready | input | 1 | Hand-off taken |
| mem_valid | output | 1 | Memory fetch action valid |
| mem_ready | input | 1 | Memory fetch taken |
| act_cpu | output | CPU_W | Requester of the current action |
| act_addr | output | ADDR_W | Line of the current action |
| act_excl | output | 1 | Type of the current action |
| fwd_target | output | CPU_W | Owning CPU for a forward |
| fwd_done | input | 1 | A forward has completed |
| fwd_done_addr | input | ADDR_W | Line of the completed forward |
| evict_valid | input | 1 | An L1 evicts a line into this bank |
| evict_cpu | input | CPU_W | Evicting CPU |
| evict_addr | input | ADDR_W | Evicted line |
| rmt_upd | input | 1 | Write the remote record of a line |
| rmt_upd_addr | input | ADDR_W | Line whose remote record is written |
| rmt_upd_state | input | 2 | Remote state code (see R2) |
| bank_err | output | 1 | Pulse: request had a foreign bank index |

## Verification
The decision is combinational on the offered request, so `req_ready` is due in the cycle the request is driven. The bench samples it one time unit after driving at the falling edge, before the accepting rising edge. The chosen action, its payload and `bank_err` come from a single register stage and are due in the cycle after the accepting edge. The bench checks them at the next falling edge. Strobes on eviction, remote record and completion take effect at the edge that samples them, and the next request that is driven observes them. For blocked requests, `req_ready` is checked over several cycles before the request is withdrawn.

// File: rtl/l2d_pkg.sv
package l2d_pkg;
  typedef enum logic [1:0] {
    ACT_L2  = 2'd0,
    ACT_FWD = 2'd1,
    ACT_PE  = 2'd2,
    ACT_MEM = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } lstate_e;
endpackage

// File: rtl/l2d_dup_tags.sv
module l2d_dup_tags import l2d_pkg::*; #(
  parameter int NUM_CPU   = 8,
  parameter int ADDR_W    = 16,
  parameter int BANK_BITS = 2,
  parameter int DUP_SETS  = 4,
  localparam int CPU_W    = $clog2(NUM_CPU),
  localparam int IDX_W    = $clog2(DUP_SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              owner_vld,
  output logic [CPU_W-1:0]  owner_id,
  input  logic              upd_en,
  input  logic [CPU_W-1:0]  upd_cpu,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_excl,
  input  logic              ev_en,
  input  logic [CPU_W-1:0]  ev_cpu,
  input  logic [ADDR_W-1:0] ev_addr
);
  logic [ADDR_W-1:0] tag_q [NUM_CPU][DUP_SETS];
  lstate_e           st_q  [NUM_CPU][DUP_SETS];
  logic [NUM_CPU-1:0] excl_vec;
  logic [IDX_W-1:0]   lk_idx, upd_idx, ev_idx;

  assign lk_idx  = lk_addr[BANK_BITS +: IDX_W];
  assign upd_idx = upd_addr[BANK_BITS +: IDX_W];
  assign ev_idx  = ev_addr[BANK_BITS +: IDX_W];

  always_comb begin
    owner_vld = 1'b0;
    owner_id  = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      excl_vec[c] = (st_q[c][lk_idx] == LS_EXC) && (tag_q[c][lk_idx] == lk_addr);
      if (excl_vec[c]) begin
        owner_vld = 1'b1;
        owner_id  = CPU_W'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CPU; c++)
        for (int s = 0; s < DUP_SETS; s++) begin
          tag_q[c][s] <= '0;
          st_q[c][s]  <= LS_INV;
        end
    end else begin
      for (int c = 0; c < NUM_CPU; c++)
        for (int s = 0; s < DUP_SETS; s++) begin
          // R4: an eviction drops the evicting CPU's copy
          if (ev_en && ev_cpu == CPU_W'(c) && ev_idx == IDX_W'(s) && tag_q[c][s] == ev_addr)
            st_q[c][s] <= LS_INV;
          if (upd_en && upd_idx == IDX_W'(s)) begin
            if (upd_cpu == CPU_W'(c)) begin
              tag_q[c][s] <= upd_addr;
              st_q[c][s]  <= upd_excl ? LS_EXC : LS_SHR;
            end else if (tag_q[c][s] == upd_addr) begin
              if (upd_excl)                 st_q[c][s] <= LS_INV;
              else if (st_q[c][s] == LS_EXC) st_q[c][s] <= LS_SHR;
            end
          end
        end
    end
  end

  // R3/R5: no line ever has two exclusive L1 owners
  a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(excl_vec));
endmodule

// File: rtl/l2d_line_dir.sv
module l2d_line_dir #(
  parameter int ADDR_W    = 16,
  parameter int BANK_BITS = 2,
  parameter int L2_SETS   = 16,
  parameter int RMT_SETS  = 8,
  localparam int L2_IW    = $clog2(L2_SETS),
  localparam int RM_IW    = $clog2(RMT_SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              l2_hit,
  output logic [1:0]        rmt_state,
  input  logic              ins_en,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              rmt_en,
  input  logic [ADDR_W-1:0] rmt_addr,
  input  logic [1:0]        rmt_st
);
  logic              l2_vld_q [L2_SETS];
  logic [ADDR_W-1:0] l2_tag_q [L2_SETS];
  logic [ADDR_W-1:0] rm_tag_q [RMT_SETS];
  logic [1:0]        rm_st_q  [RMT_SETS];
  logic [L2_IW-1:0]  lk_l2, ins_idx;
  logic [RM_IW-1:0]  lk_rm, rm_idx;

  assign lk_l2   = lk_addr[BANK_BITS +: L2_IW];
  assign ins_idx = ins_addr[BANK_BITS +: L2_IW];
  assign lk_rm   = lk_addr[BANK_BITS +: RM_IW];
  assign rm_idx  = rmt_addr[BANK_BITS +: RM_IW];

  assign l2_hit    = l2_vld_q[lk_l2] && (l2_tag_q[lk_l2] == lk_addr);
  assign rmt_state = (rm_tag_q[lk_rm] == lk_addr) ? rm_st_q[lk_rm] : 2'b00;

  // R4: victim-only install
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < L2_SETS; s++) begin
        l2_vld_q[s] <= 1'b0;
        l2_tag_q[s] <= '0;
      end
    end else if (ins_en) begin
      l2_vld_q[ins_idx] <= 1'b1;
      l2_tag_q[ins_idx] <= ins_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < RMT_SETS; s++) begin
        rm_tag_q[s] <= '0;
        rm_st_q[s]  <= 2'b00;
      end
    end else if (rmt_en) begin
      rm_tag_q[rm_idx] <= rmt_addr;
      rm_st_q[rm_idx]  <= rmt_st;
    end
  end

  a_r4_victim_install: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> (l2_vld_q[$past(ins_idx)] && l2_tag_q[$past(ins_idx)] == $past(ins_addr)));
endmodule

// File: rtl/l2d_fwd_table.sv
module l2d_fwd_table #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              hit,
  output logic              full,
  input  logic              alloc_en,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              rel_en,
  input  logic [ADDR_W-1:0] rel_addr
);
  logic [ENTRIES-1:0] vld_q;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [ENTRIES-1:0] free_oh;
  logic               found;

  assign full = &vld_q;

  always_comb begin
    hit     = 1'b0;
    free_oh = '0;
    found   = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (vld_q[e] && addr_q[e] == chk_addr) hit = 1'b1;
      if (!vld_q[e] && !found) begin
        free_oh[e] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int e = 0; e < ENTRIES; e++) addr_q[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (rel_en && vld_q[e] && addr_q[e] == rel_addr) vld_q[e] <= 1'b0;
        if (alloc_en && free_oh[e]) begin
          vld_q[e]  <= 1'b1;
          addr_q[e] <= alloc_addr;
        end
      end
    end
  end

  a_r7_no_alloc_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);

  a_r6_no_realloc_pending: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !(hit && chk_addr == alloc_addr));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_uniq_i
    for (genvar j = i + 1; j < ENTRIES; j++) begin : g_uniq_j
      a_r6_unique_line: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld_q[i] && vld_q[j] && addr_q[i] == addr_q[j]));
    end
  end
endmodule

// File: rtl/l2_bank_dispatch.sv
module l2_bank_dispatch import l2d_pkg::*; #(
  parameter int NUM_CPU   = 8,
  parameter int ADDR_W    = 16,
  parameter int BANK_BITS = 2,
  parameter int BANK_ID   = 0,
  parameter int L2_SETS   = 16,
  parameter int DUP_SETS  = 4,
  parameter int RMT_SETS  = 8,
  parameter int FWD_SLOTS = 4,
  localparam int CPU_W    = $clog2(NUM_CPU)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_excl,
  output logic              l2_valid,
  input  logic              l2_ready,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic              pe_valid,
  input  logic              pe_ready,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [CPU_W-1:0]  act_cpu,
  output logic [ADDR_W-1:0] act_addr,
  output logic              act_excl,
  output logic [CPU_W-1:0]  fwd_target,
  input  logic              fwd_done,
  input  logic [ADDR_W-1:0] fwd_done_addr,
  input  logic              evict_valid,
  input  logic [CPU_W-1:0]  evict_cpu,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic              rmt_upd,
  input  logic [ADDR_W-1:0] rmt_upd_addr,
  input  logic [1:0]        rmt_upd_state,
  output logic              bank_err
);
  logic             owner_vld, l2_hit, fwd_hit, fwd_full;
  logic [CPU_W-1:0] owner_id;
  logic [1:0]       rmt_state;
  logic             in_bank, rm_conf, out_free, sel_ready, acc, acc_ok;
  act_e             dec_act;

  logic              out_vld_q, err_q, out_excl_q;
  act_e              out_act_q;
  logic [CPU_W-1:0]  out_cpu_q, out_own_q;
  logic [ADDR_W-1:0] out_addr_q;

  l2d_dup_tags #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS),
                 .DUP_SETS(DUP_SETS)) u_dup (
    .clk(clk), .rst_n(rst_n), .lk_addr(req_addr),
    .owner_vld(owner_vld), .owner_id(owner_id),
    .upd_en(acc_ok && dec_act != ACT_PE), .upd_cpu(req_cpu),
    .upd_addr(req_addr), .upd_excl(req_excl),
    .ev_en(evict_valid), .ev_cpu(evict_cpu), .ev_addr(evict_addr));

  l2d_line_dir #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .L2_SETS(L2_SETS),
                 .RMT_SETS(RMT_SETS)) u_dir (
    .clk(clk), .rst_n(rst_n), .lk_addr(req_addr),
    .l2_hit(l2_hit), .rmt_state(rmt_state),
    .ins_en(evict_valid), .ins_addr(evict_addr),
    .rmt_en(rmt_upd), .rmt_addr(rmt_upd_addr), .rmt_st(rmt_upd_state));

  l2d_fwd_table #(.ENTRIES(FWD_SLOTS), .ADDR_W(ADDR_W)) u_fwd (
    .clk(clk), .rst_n(rst_n), .chk_addr(req_addr),
    .hit(fwd_hit), .full(fwd_full),
    .alloc_en(acc_ok && dec_act == ACT_FWD), .alloc_addr(req_addr),
    .rel_en(fwd_done), .rel_addr(fwd_done_addr));

  assign in_bank = (req_addr[BANK_BITS-1:0] == BANK_BITS'(BANK_ID));
  // R2: exclusive remote copy clashes with anything, shared only with a write
  assign rm_conf = rmt_state[1] || (rmt_state == 2'b01 && req_excl);

  // R1: service path priority
  always_comb begin
    if (rm_conf)                               dec_act = ACT_PE;
    else if (owner_vld && owner_id != req_cpu) dec_act = ACT_FWD;
    else if (l2_hit)                           dec_act = ACT_L2;
    else                                       dec_act = ACT_MEM;
  end

  always_comb begin
    case (out_act_q)
      ACT_L2:  sel_ready = l2_ready;
      ACT_FWD: sel_ready = fwd_ready;
      ACT_PE:  sel_ready = pe_ready;
      default: sel_ready = mem_ready;
    endcase
  end

  assign out_free  = !out_vld_q || sel_ready;
  assign req_ready = !in_bank ||
                     (out_free && !fwd_hit && !(dec_act == ACT_FWD && fwd_full));
  assign acc    = req_valid && req_ready;
  assign acc_ok = acc && in_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_q  <= 1'b0;
      out_act_q  <= ACT_L2;
      out_cpu_q  <= '0;
      out_addr_q <= '0;
      out_excl_q <= 1'b0;
      out_own_q  <= '0;
      err_q      <= 1'b0;
    end else begin
      err_q <= acc && !in_bank;
      if (acc_ok) begin
        out_vld_q  <= 1'b1;
        out_act_q  <= dec_act;
        out_cpu_q  <= req_cpu;
        out_addr_q <= req_addr;
        out_excl_q <= req_excl;
        out_own_q  <= owner_id;
      end else if (sel_ready) begin
        out_vld_q <= 1'b0;
      end
    end
  end

  assign l2_valid   = out_vld_q && out_act_q == ACT_L2;
  assign fwd_valid  = out_vld_q && out_act_q == ACT_FWD;
  assign pe_valid   = out_vld_q && out_act_q == ACT_PE;
  assign mem_valid  = out_vld_q && out_act_q == ACT_MEM;
  assign act_cpu    = out_cpu_q;
  assign act_addr   = out_addr_q;
  assign act_excl   = out_excl_q;
  assign fwd_target = out_own_q;
  assign bank_err   = err_q;

  a_r10_hold_action: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_q && !sel_ready) |=> (out_vld_q && $stable(out_act_q) &&
                                   $stable(out_addr_q) && $stable(out_cpu_q)));

  a_r8_err_after_foreign: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !in_bank) |=> bank_err);

  a_r9_action_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> ((l2_valid || fwd_valid || pe_valid || mem_valid) &&
                act_addr == $past(req_addr) && act_cpu == $past(req_cpu)));
endmodule

// File: tb/l2_bank_dispatch_bench.sv
`timescale 1ns/1ps
module l2_bank_dispatch_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_excl = 0;
  logic [2:0] req_cpu = 0;
  logic [15:0] req_addr = 0;
  logic l2_ready = 1, fwd_ready = 1, pe_ready = 1, mem_ready = 1;
  logic fwd_done = 0, evict_valid = 0, rmt_upd = 0;
  logic [15:0] fwd_done_addr = 0, evict_addr = 0, rmt_upd_addr = 0;
  logic [2:0] evict_cpu = 0;
  logic [1:0] rmt_upd_state = 0;
  logic req_ready, l2_valid, fwd_valid, pe_valid, mem_valid, act_excl, bank_err;
  logic [2:0] act_cpu, fwd_target;
  logic [15:0] act_addr;

  always #4 clk = ~clk;

  l2_bank_dispatch u_l2_bank_dispatch (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_dup_a [8][4];
  int          m_dup_s [8][4];
  bit          m_l2_v [16];
  logic [15:0] m_l2_a [16];
  logic [15:0] m_rm_a [8];
  logic [1:0]  m_rm_s [8];
  bit          m_pv [4];
  logic [15:0] m_pa [4];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(int tag, int idx);
    return {tag[9:0], idx[3:0], 2'b00};
  endfunction

  function automatic bit pend_hit(logic [15:0] a);
    for (int e = 0; e < 4; e++) if (m_pv[e] && m_pa[e] == a) return 1;
    return 0;
  endfunction

  function automatic int pend_cnt();
    int n = 0;
    for (int e = 0; e < 4; e++) if (m_pv[e]) n++;
    return n;
  endfunction

  // 0 L2, 1 FWD, 2 PE, 3 MEM
  function automatic int exp_act(int cpu, logic [15:0] a, bit ex, output int own);
    logic [1:0] rs;
    rs = (m_rm_a[a[4:2]] == a) ? m_rm_s[a[4:2]] : 2'b00;
    own = -1;
    for (int c = 0; c < 8; c++)
      if (m_dup_s[c][a[3:2]] == 2 && m_dup_a[c][a[3:2]] == a) own = c;
    if (rs[1] || (rs == 2'b01 && ex)) return 2;
    if (own >= 0 && own != cpu) return 1;
    if (m_l2_v[a[5:2]] && m_l2_a[a[5:2]] == a) return 0;
    return 3;
  endfunction

  task automatic model_apply(int cpu, logic [15:0] a, bit ex, int act);
    int d = int'(a[3:2]);
    if (act == 2) return;
    for (int c = 0; c < 8; c++) begin
      if (c == cpu) begin
        m_dup_a[c][d] = a; m_dup_s[c][d] = ex ? 2 : 1;
      end else if (m_dup_a[c][d] == a) begin
        if (ex) m_dup_s[c][d] = 0;
        else if (m_dup_s[c][d] == 2) m_dup_s[c][d] = 1;
      end
    end
    if (act == 1)
      for (int e = 0; e < 4; e++)
        if (!m_pv[e]) begin m_pv[e] = 1; m_pa[e] = a; break; end
  endtask

  function automatic string act_tag(int ea);
    case (ea)
      0: return "R4 l2";
      1: return "R3 fwd";
      2: return "R2 pe";
      default: return "R1 mem";
    endcase
  endfunction

  task automatic do_req(int cpu, logic [15:0] a, bit ex, string note);
    int ea, own;
    bit wrong, blk;
    wrong = (a[1:0] != 2'b00);
    ea  = exp_act(cpu, a, ex, own);
    blk = !wrong && (pend_hit(a) || (ea == 1 && pend_cnt() == 4));
    @(negedge clk);
    req_valid = 1; req_cpu = cpu[2:0]; req_addr = a; req_excl = ex;
    #1;
    if (wrong) begin
      chk(req_ready == 1, {"R8 ready ", note}, req_ready, 1);
      @(negedge clk); req_valid = 0;
      chk(bank_err == 1, {"R8 err ", note}, bank_err, 1);
      chk({l2_valid, fwd_valid, pe_valid, mem_valid} == 4'b0, {"R8 noact ", note},
          {l2_valid, fwd_valid, pe_valid, mem_valid}, 0);
      @(negedge clk);
      chk(bank_err == 0, {"R8 pulse ", note}, bank_err, 0);
    end else if (blk) begin
      for (int k = 0; k < 3; k++) begin
        chk(req_ready == 0, pend_hit(a) ? {"R6 hold ", note} : {"R7 full ", note},
            req_ready, 0);
        @(negedge clk); #1;
      end
      req_valid = 0;
    end else begin
      chk(req_ready == 1, {"R9 ready ", note}, req_ready, 1);
      @(negedge clk); req_valid = 0;
      chk({l2_valid, fwd_valid, pe_valid, mem_valid} == (4'b1000 >> ea),
          {act_tag(ea), " ", note}, {l2_valid, fwd_valid, pe_valid, mem_valid},
          4'b1000 >> ea);
      chk(act_addr == a && act_cpu == cpu[2:0] && act_excl == ex,
          {"R9 payload ", note}, {act_cpu, act_excl, act_addr}, {cpu[2:0], ex, a});
      if (ea == 1)
        chk(fwd_target == own[2:0], {"R3 target ", note}, fwd_target, own);
      model_apply(cpu, a, ex, ea);
    end
  endtask

  task automatic do_evict(int cpu, logic [15:0] a);
    @(negedge clk);
    evict_valid = 1; evict_cpu = cpu[2:0]; evict_addr = a;
    @(negedge clk); evict_valid = 0;
    if (m_dup_a[cpu][a[3:2]] == a) m_dup_s[cpu][a[3:2]] = 0;
    m_l2_v[a[5:2]] = 1; m_l2_a[a[5:2]] = a;
  endtask

  task automatic do_rmt(logic [15:0] a, logic [1:0] s);
    @(negedge clk);
    rmt_upd = 1; rmt_upd_addr = a; rmt_upd_state = s;
    @(negedge clk); rmt_upd = 0;
    m_rm_a[a[4:2]] = a; m_rm_s[a[4:2]] = s;
  endtask

  task automatic do_done(logic [15:0] a);
    @(negedge clk);
    fwd_done = 1; fwd_done_addr = a;
    @(negedge clk); fwd_done = 0;
    for (int e = 0; e < 4; e++) if (m_pv[e] && m_pa[e] == a) m_pv[e] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] la, lb;
    void'($urandom(32'd20250601));
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 4; s++) begin m_dup_a[c][s] = 0; m_dup_s[c][s] = 0; end
    for (int s = 0; s < 16; s++) begin m_l2_v[s] = 0; m_l2_a[s] = 0; end
    for (int s = 0; s < 8; s++) begin m_rm_a[s] = 0; m_rm_s[s] = 0; end
    for (int e = 0; e < 4; e++) begin m_pv[e] = 0; m_pa[e] = 0; end
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk({l2_valid, fwd_valid, pe_valid, mem_valid, bank_err} == 5'b0, "R11 idle",
        {l2_valid, fwd_valid, pe_valid, mem_valid, bank_err}, 0);
    chk(req_ready == 1, "R11 ready", req_ready, 1);

    // back-pressure with two fresh lines
    la = mk(20, 0); lb = mk(21, 1);
    mem_ready = 0;
    @(negedge clk); req_valid = 1; req_cpu = 0; req_addr = la; req_excl = 0;
    @(negedge clk); req_addr = lb; req_cpu = 1; #1;
    chk(mem_valid && act_addr == la, "R9 first", act_addr, la);
    for (int k = 0; k < 3; k++) begin
      chk(mem_valid && act_addr == la, "R10 held", act_addr, la);
      chk(req_ready == 0, "R10 stall", req_ready, 0);
      @(negedge clk); #1;
    end
    mem_ready = 1; #1;
    chk(req_ready == 1, "R10 release", req_ready, 1);
    @(negedge clk); req_valid = 0;
    chk(mem_valid && act_addr == lb, "R10 next", act_addr, lb);
    model_apply(0, la, 0, 3); model_apply(1, lb, 0, 3);

    // non-inclusive: memory fetch does not install
    do_req(2, la, 0, "R4 no install");
    // victim install, then L2 reply
    do_evict(0, la);
    do_req(3, la, 0, "R4 after evict");
    // forward, downgrade, block, release
    la = mk(30, 2);
    do_req(1, la, 1, "R5 own");
    do_req(2, la, 0, "R3 read fwd");
    do_req(3, la, 0, "R6 blocked");
    do_done(la);
    do_req(3, la, 0, "R3 downgraded");
    do_req(4, la, 1, "R5 excl");
    do_req(5, la, 1, "R3 excl fwd");
    do_done(la);
    do_req(4, la, 0, "R3 new owner");
    do_done(la);
    // remote conflicts
    lb = mk(40, 3);
    do_rmt(lb, 2'b01);
    do_req(0, lb, 0, "R2 shared read");
    do_req(1, lb, 1, "R2 shared excl");
    do_rmt(lb, 2'b10);
    do_req(2, lb, 0, "R2 excl read");
    do_rmt(lb, 2'b00);
    // foreign bank
    do_req(0, 16'h0041, 0, "R8 bank1");
    do_req(0, 16'h0043, 1, "R8 bank3");
    // fill the forward table
    for (int i = 0; i < 4; i++) do_req(1, mk(50, i), 1, "R7 own");
    for (int i = 0; i < 4; i++) do_req(2, mk(50, i), 0, "R7 fill");
    do_req(3, mk(51, 4), 1, "R7 own5");
    do_req(5, mk(51, 4), 0, "R7 full");
    do_done(mk(50, 0));
    do_req(5, mk(51, 4), 0, "R7 freed");
    for (int i = 1; i < 4; i++) do_done(mk(50, i));
    do_done(mk(51, 4));

    // constrained random
    for (int n = 0; n < 1500; n++) begin
      int op = $urandom % 100;
      if (op < 60) begin
        int bk = ($urandom % 8 == 0) ? 1 + ($urandom % 3) : 0;
        logic [15:0] a = {8'd0, 2'(($urandom % 4)), 4'(($urandom % 16)), 2'(bk)};
        do_req($urandom % 8, a, 1'($urandom % 2), "rand");
      end else if (op < 75) begin
        int c = $urandom % 8, s = $urandom % 4;
        if (m_dup_s[c][s] != 0) do_evict(c, m_dup_a[c][s]);
      end else if (op < 85) begin
        logic [15:0] a = {8'd0, 2'(($urandom % 4)), 4'(($urandom % 16)), 2'b00};
        do_rmt(a, 2'(($urandom % 3)));
      end else begin
        int e = $urandom % 4;
        if (m_pv[e]) do_done(m_pa[e]);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule